// File: doc/BRIEF.md
# SPI Register Access Slave

This block is an SPI slave that lets an external host reach a bank of 64 byte-wide registers, packet buffer ports among them, through a simple synchronous register port on the core side. Every transaction opens with a command byte. Bit 7 of that byte gives the direction, bit 6 asks for address stepping, and bits 5..0 carry the starting address. Data bytes follow for as long as slave select stays low.

When stepping is off, a burst keeps hitting one address, so the host can stream bytes into or out of a buffer port as if it were a FIFO. When stepping is on, a burst walks through consecutive registers. All SPI pins are oversampled by the core clock through synchronizers. SCK must stay in each phase for at least 10 core clock cycles. The pad pair can work as separate MOSI/MISO lines or as one shared bidirectional data line. In shared mode, the pad ring turns the line around using the block's output enable.

Top module: `spi_regport_slave`

## Requirements
- R1: Command bit 7 = 1 makes the data bytes of the transaction register writes. Bit 7 = 0 makes them register reads.
- R2: With command bit 6 = 1, the address advances by one after each data byte and wraps from 63 to 0.
- R3: With command bit 6 = 0, every data byte of the burst uses the command's address.
- R4: Command bits 5..0 give the first address accessed.
- R5: SPI mode 0 with the most significant bit first. Input data is taken on the rising SCK edge. Output data changes only after a falling SCK edge and holds steady while SCK is high.
- R6: A burst runs until slave select (`ss_n`, active low) goes high. Each complete write data byte produces exactly one `reg_wr_en` pulse, carrying that byte on `reg_wdata`.
- R7: A read issues one `reg_rd_en` pulse when the command byte completes and one when each data byte completes. The value fetched is shifted out during the following byte. A read burst of N bytes therefore issues N+1 fetches.
- R8: Raising `ss_n` before a byte is complete discards the partial byte without any strobe. The next transaction starts from a fresh command byte.
- R9: With `wire3_en` = 1, input bits come from `sdio_i`. `sdio_oe` is high only during the data bytes of a read and falls after slave select is released. `miso_oe` stays low.
- R10: With `wire3_en` = 0, input bits come from `mosi`. `miso_oe` is high exactly while the block is selected, and `sdio_oe` stays low.
- R11: After reset, no strobe is active, both output enables are low, and the block waits for a command byte.
- R12: `reg_rdata` is taken one clock after the cycle in which `reg_rd_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wire3_en | input | 1 | 1 selects the single shared data line |
| ss_n | input | 1 | Slave select, active low |
| sck | input | 1 | Serial clock, idles low |
| mosi | input | 1 | Serial data in, 4-wire mode |
| miso | output | 1 | Serial data out, 4-wire mode |
| miso_oe | output | 1 | Drive enable for miso |
| sdio_i | input | 1 | Shared line, input side |
| sdio_o | output | 1 | Shared line, output side |
| sdio_oe | output | 1 | Drive enable for the shared line |
| reg_addr | output | 6 | Register port address |
| reg_wr_en | output | 1 | Register write strobe |
| reg_wdata | output | 8 | Register write data |
| reg_rd_en | output | 1 | Register read strobe |
| reg_rdata | input | 8 | Register read data, one clock after reg_rd_en |

## Verification
A bit counter that has drifted out of step shows up on the very next command. The address decodes wrongly, so strobes land on the wrong register or a read returns a neighbour's value within one byte time. A wrong address pointer or a wrong stepping decision shows on `reg_addr` at the second data byte of a burst. A missing or extra prefetch only shows at a FIFO-style port, where the next read returns a value that is off by the miscount. A stale output enable shows as the shared line still being driven during a command byte or after deselect, one clock after the event.

// File: rtl/spi_rp_pkg.sv
package spi_rp_pkg;
  localparam int BYTE_W  = 8;
  localparam int ADDR_W  = 6;
  localparam int CNT_W   = $clog2(BYTE_W);
  localparam int DIR_BIT = 7;
  localparam int INC_BIT = 6;

  typedef enum logic {
    PH_CMD  = 1'b0,
    PH_DATA = 1'b1
  } phase_e;

  typedef struct packed {
    logic              wr;
    logic              inc;
    logic [ADDR_W-1:0] addr;
  } cmd_t;

  // split a command byte into its fields
  function automatic cmd_t decode_cmd(input logic [BYTE_W-1:0] b);
    cmd_t c;
    c.wr   = b[DIR_BIT];
    c.inc  = b[INC_BIT];
    c.addr = b[ADDR_W-1:0];
    return c;
  endfunction

  // address used by the next byte of a burst
  function automatic logic [ADDR_W-1:0] next_addr(input logic [ADDR_W-1:0] a,
                                                  input logic inc);
    return inc ? a + ADDR_W'(1) : a;
  endfunction
endpackage

// File: rtl/spi_rp_sync.sv
module spi_rp_sync #(
  parameter int               STAGES  = 2,
  parameter int               WIDTH   = 3,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL[g]}};
      else        chain <= {chain[STAGES-2:0], d[g]};
    end
    assign q[g] = chain[STAGES-1];
  end
endmodule

// File: rtl/spi_rp_shifter.sv
module spi_rp_shifter
  import spi_rp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              sck_lvl,
  input  logic              din,
  input  logic              stage_we,
  input  logic [BYTE_W-1:0] stage_data,
  output logic              byte_done,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              boundary_fall,
  output logic              tx_bit
);
  logic              sck_q;
  logic              sck_rise, sck_fall;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] rx_sr, tx_sr, stage;
  logic              last_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_q <= 1'b0;
    else        sck_q <= sck_lvl;
  end

  assign sck_rise      = active &  sck_lvl & ~sck_q;
  assign sck_fall      = active & ~sck_lvl &  sck_q;
  assign last_bit      = (bit_cnt == CNT_W'(BYTE_W-1));
  assign boundary_fall = sck_fall & (bit_cnt == '0);
  assign tx_bit        = tx_sr[BYTE_W-1];

  // bit counter and receive shift register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt   <= '0;
      rx_sr     <= '0;
      rx_byte   <= '0;
      byte_done <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      if (!active) begin
        bit_cnt <= '0;
      end else if (sck_rise) begin
        bit_cnt <= bit_cnt + CNT_W'(1);
        rx_sr   <= {rx_sr[BYTE_W-2:0], din};
        if (last_bit) begin
          byte_done <= 1'b1;
          rx_byte   <= {rx_sr[BYTE_W-2:0], din};
        end
      end
    end
  end

  // transmit staging and shift register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage <= '0;
      tx_sr <= '0;
    end else begin
      if (stage_we) stage <= stage_data;
      if (boundary_fall)  tx_sr <= stage;
      else if (sck_fall)  tx_sr <= {tx_sr[BYTE_W-2:0], 1'b0};
    end
  end

  assert_bitcnt_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (bit_cnt == '0));

  assert_byte_after_last_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |-> $past(last_bit));

  assert_tx_hold_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (active && sck_lvl && sck_q) |=> $stable(tx_bit));
endmodule

// File: rtl/spi_rp_ctrl.sv
module spi_rp_ctrl
  import spi_rp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              wire3_en,
  input  logic              byte_done,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              boundary_fall,
  output logic [ADDR_W-1:0] reg_addr,
  output logic              reg_wr_en,
  output logic [BYTE_W-1:0] reg_wdata,
  output logic              reg_rd_en,
  output logic              stage_we,
  output logic              sdio_oe
);
  phase_e            phase;
  logic              cur_wr, cur_inc;
  logic [ADDR_W-1:0] ptr;
  cmd_t              cmd;
  logic [ADDR_W-1:0] ptr_next;

  assign cmd      = decode_cmd(rx_byte);
  assign ptr_next = next_addr(ptr, cur_inc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_CMD;
      cur_wr    <= 1'b0;
      cur_inc   <= 1'b0;
      ptr       <= '0;
      reg_addr  <= '0;
      reg_wdata <= '0;
      reg_wr_en <= 1'b0;
      reg_rd_en <= 1'b0;
      stage_we  <= 1'b0;
      sdio_oe   <= 1'b0;
    end else begin
      reg_wr_en <= 1'b0;
      reg_rd_en <= 1'b0;
      stage_we  <= reg_rd_en;
      if (!active) begin
        phase   <= PH_CMD;
        sdio_oe <= 1'b0;
      end else begin
        if (byte_done) begin
          if (phase == PH_CMD) begin
            cur_wr   <= cmd.wr;
            cur_inc  <= cmd.inc;
            ptr      <= cmd.addr;
            reg_addr <= cmd.addr;
            phase    <= PH_DATA;
            if (!cmd.wr) reg_rd_en <= 1'b1;
          end else if (cur_wr) begin
            reg_addr  <= ptr;
            reg_wdata <= rx_byte;
            reg_wr_en <= 1'b1;
            ptr       <= ptr_next;
          end else begin
            reg_addr  <= ptr_next;
            reg_rd_en <= 1'b1;
            ptr       <= ptr_next;
          end
        end
        if (boundary_fall && phase == PH_DATA && !cur_wr && wire3_en)
          sdio_oe <= 1'b1;
      end
    end
  end

  assert_single_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr_en && reg_rd_en));

  assert_strobe_needs_byte_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en || reg_rd_en) |-> $past(byte_done));

  assert_fixed_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && phase == PH_DATA && !cur_inc) |=> $stable(ptr));

  assert_step_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (active && byte_done && phase == PH_DATA && cur_inc) |=>
      (ptr == ADDR_W'($past(ptr) + 1)));

  assert_oe_read_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sdio_oe |-> (phase == PH_DATA && !cur_wr));

  assert_oe_released_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !sdio_oe);
endmodule

// File: rtl/spi_regport_slave.sv
module spi_regport_slave
  import spi_rp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wire3_en,
  input  logic              ss_n,
  input  logic              sck,
  input  logic              mosi,
  output logic              miso,
  output logic              miso_oe,
  input  logic              sdio_i,
  output logic              sdio_o,
  output logic              sdio_oe,
  output logic [ADDR_W-1:0] reg_addr,
  output logic              reg_wr_en,
  output logic [BYTE_W-1:0] reg_wdata,
  output logic              reg_rd_en,
  input  logic [BYTE_W-1:0] reg_rdata
);
  logic [2:0]        pins_s;
  logic              ss_s, sck_s, din_s, active;
  logic              byte_done, boundary_fall, stage_we, tx_bit;
  logic [BYTE_W-1:0] rx_byte;

  spi_rp_sync #(.STAGES(SYNC_STAGES), .WIDTH(3), .RST_VAL(3'b100)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({ss_n, sck, (wire3_en ? sdio_i : mosi)}),
    .q     (pins_s)
  );

  assign ss_s   = pins_s[2];
  assign sck_s  = pins_s[1];
  assign din_s  = pins_s[0];
  assign active = ~ss_s;

  spi_rp_shifter u_shift (
    .clk           (clk),
    .rst_n         (rst_n),
    .active        (active),
    .sck_lvl       (sck_s),
    .din           (din_s),
    .stage_we      (stage_we),
    .stage_data    (reg_rdata),
    .byte_done     (byte_done),
    .rx_byte       (rx_byte),
    .boundary_fall (boundary_fall),
    .tx_bit        (tx_bit)
  );

  spi_rp_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .active        (active),
    .wire3_en      (wire3_en),
    .byte_done     (byte_done),
    .rx_byte       (rx_byte),
    .boundary_fall (boundary_fall),
    .reg_addr      (reg_addr),
    .reg_wr_en     (reg_wr_en),
    .reg_wdata     (reg_wdata),
    .reg_rd_en     (reg_rd_en),
    .stage_we      (stage_we),
    .sdio_oe       (sdio_oe)
  );

  assign miso    = tx_bit;
  assign sdio_o  = tx_bit;
  assign miso_oe = active & ~wire3_en;

  assert_no_strobe_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !$past(active)) |=> !(reg_wr_en || reg_rd_en));
endmodule

// File: tb/spi_regport_slave_bench.sv
module spi_regport_slave_bench;
  localparam int CLK_NS = 10;
  localparam int HALF   = 10;
  localparam logic [5:0] FIFO_A = 6'h20;

  logic clk = 0, rst_n = 0, wire3_en = 0, ss_n = 1, sck = 0, mosi = 0, sdio_i = 0;
  logic miso, miso_oe, sdio_o, sdio_oe, reg_wr_en, reg_rd_en;
  logic [5:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;

  int checks = 0, errors = 0;
  int wr_cnt = 0, rd_cnt = 0;
  logic [7:0] mem [64];
  logic [7:0] fifo_v;
  logic [7:0] rbuf [8];
  logic oe_seen_hi, oe_seen_lo, hold_ok;

  always #(CLK_NS/2) clk = ~clk;

  spi_regport_slave u_spi_regport_slave (
    .clk(clk), .rst_n(rst_n), .wire3_en(wire3_en), .ss_n(ss_n), .sck(sck),
    .mosi(mosi), .miso(miso), .miso_oe(miso_oe), .sdio_i(sdio_i),
    .sdio_o(sdio_o), .sdio_oe(sdio_oe), .reg_addr(reg_addr),
    .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata), .reg_rd_en(reg_rd_en),
    .reg_rdata(reg_rdata)
  );

  function automatic logic [7:0] init_val(input int a);
    return 8'((a * 7) + 3);
  endfunction

  // register bank model: read data one clock after the strobe (R12)
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) mem[i] <= init_val(i);
      fifo_v    <= 8'h40;
      reg_rdata <= 8'h00;
    end else begin
      if (reg_wr_en) begin
        mem[reg_addr] <= reg_wdata;
        wr_cnt <= wr_cnt + 1;
      end
      if (reg_rd_en) begin
        rd_cnt <= rd_cnt + 1;
        if (reg_addr == FIFO_A) begin
          reg_rdata <= fifo_v;
          fifo_v    <= fifo_v + 8'd1;
        end else begin
          reg_rdata <= mem[reg_addr];
        end
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic out_pin();
    return wire3_en ? sdio_o : miso;
  endfunction

  // one byte, MSB first; samples output at the rising edge and at the end of the high phase
  task automatic xfer_bits(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - nbits; i--) begin
      if (wire3_en) sdio_i = tx[i]; else mosi = tx[i];
      wait_clk(HALF);
      sck = 1;
      rx[i] = out_pin();
      if (sdio_oe) oe_seen_hi = 1; else oe_seen_lo = 1;
      wait_clk(HALF - 1);
      if (out_pin() !== rx[i]) hold_ok = 0;
      wait_clk(1);
      sck = 0;
    end
  endtask

  task automatic select();
    ss_n = 0;
    wait_clk(HALF);
  endtask

  task automatic deselect();
    wait_clk(HALF);
    ss_n = 1;
    wait_clk(4 * HALF);
  endtask

  task automatic write_burst(input logic [7:0] cmd, input logic [7:0] d0,
                             input logic [7:0] d1, input logic [7:0] d2);
    logic [7:0] rx;
    select();
    xfer_bits(cmd, 8, rx);
    xfer_bits(d0, 8, rx);
    xfer_bits(d1, 8, rx);
    xfer_bits(d2, 8, rx);
    deselect();
  endtask

  task automatic read_burst(input logic [7:0] cmd, input int n);
    logic [7:0] rx;
    select();
    oe_seen_hi = 0; oe_seen_lo = 0;
    xfer_bits(cmd, 8, rx);
    check("R9 shared line idle during command", 32'(oe_seen_hi), 0);
    oe_seen_hi = 0; oe_seen_lo = 0; hold_ok = 1;
    for (int k = 0; k < n; k++) begin
      xfer_bits(8'h00, 8, rx);
      rbuf[k] = rx;
    end
    deselect();
  endtask

  task automatic t_reset();
    check("R11 reg_wr_en idle", 32'(reg_wr_en), 0);
    check("R11 reg_rd_en idle", 32'(reg_rd_en), 0);
    check("R11 sdio_oe low",    32'(sdio_oe), 0);
    check("R11 miso_oe low",    32'(miso_oe), 0);
  endtask

  task automatic t_write_step();
    int w0 = wr_cnt;
    write_burst(8'hC5, 8'hA1, 8'hB2, 8'hC3);
    check("R1 R6 three write strobes", 32'(wr_cnt - w0), 3);
    check("R4 first address 0x05", 32'(mem[5]), 32'hA1);
    check("R2 second address 0x06", 32'(mem[6]), 32'hB2);
    check("R2 third address 0x07",   32'(mem[7]), 32'hC3);
  endtask

  task automatic t_wrap();
    write_burst(8'hFE, 8'h11, 8'h22, 8'h33);
    check("R2 address 0x3E", 32'(mem[62]), 32'h11);
    check("R2 address 0x3F", 32'(mem[63]), 32'h22);
    check("R2 wrap to 0x00", 32'(mem[0]),  32'h33);
  endtask

  task automatic t_write_fixed();
    int w0 = wr_cnt;
    write_burst(8'h90, 8'h5A, 8'h6B, 8'h7C);
    check("R3 fixed burst strobes", 32'(wr_cnt - w0), 3);
    check("R3 last byte at 0x10", 32'(mem[16]), 32'h7C);
    check("R3 0x11 untouched", 32'(mem[17]), 32'(init_val(17)));
  endtask

  task automatic t_read_step();
    int r0 = rd_cnt;
    read_burst(8'h48, 3);
    check("R1 R4 read 0x08", 32'(rbuf[0]), 32'(init_val(8)));
    check("R2 read 0x09",    32'(rbuf[1]), 32'(init_val(9)));
    check("R2 R12 read 0x0A", 32'(rbuf[2]), 32'(init_val(10)));
    check("R7 fetch count N+1", 32'(rd_cnt - r0), 4);
    check("R5 output held while SCK high", 32'(hold_ok), 1);
    check("R10 shared line never driven", 32'(oe_seen_hi), 0);
  endtask

  task automatic t_read_fixed();
    read_burst({2'b00, FIFO_A}, 3);
    check("R3 fifo byte 0", 32'(rbuf[0]), 32'h40);
    check("R3 fifo byte 1", 32'(rbuf[1]), 32'h41);
    check("R3 fifo byte 2", 32'(rbuf[2]), 32'h42);
    read_burst({2'b00, FIFO_A}, 1);
    check("R7 prefetch consumed one entry", 32'(rbuf[0]), 32'h44);
  endtask

  task automatic t_abort();
    logic [7:0] rx;
    int w0 = wr_cnt;
    select();
    xfer_bits(8'h82, 8, rx);
    xfer_bits(8'hEE, 4, rx);
    deselect();
    check("R8 partial data byte dropped", 32'(wr_cnt - w0), 0);
    check("R8 0x02 untouched", 32'(mem[2]), 32'(init_val(2)));
    select();
    xfer_bits(8'h83, 3, rx);
    deselect();
    write_burst(8'h83, 8'h3C, 8'h3D, 8'h3E);
    check("R8 fresh command after abort", 32'(mem[3]), 32'h3E);
    check("R8 strobes after abort", 32'(wr_cnt - w0), 3);
  endtask

  task automatic t_three_wire();
    wire3_en = 1;
    wait_clk(4);
    write_burst(8'hCA, 8'h91, 8'h92, 8'h93);
    check("R9 write via shared line", 32'(mem[11]), 32'h92);
    read_burst(8'h4A, 2);
    check("R9 read via shared line 0", 32'(rbuf[0]), 32'h91);
    check("R9 read via shared line 1", 32'(rbuf[1]), 32'h92);
    check("R9 driven during read data", 32'(oe_seen_hi && !oe_seen_lo), 1);
    check("R9 released after deselect", 32'(sdio_oe), 0);
    select();
    check("R9 miso_oe low when shared", 32'(miso_oe), 0);
    deselect();
    wire3_en = 0;
    wait_clk(4);
  endtask

  task automatic t_four_wire_oe();
    select();
    check("R10 miso_oe while selected", 32'(miso_oe), 1);
    deselect();
    check("R10 miso_oe after deselect", 32'(miso_oe), 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait_clk(5);
    t_reset();
    rst_n = 1;
    wait_clk(5);
    t_reset();
    t_write_step();
    t_wrap();
    t_write_fixed();
    t_read_step();
    t_read_fixed();
    t_abort();
    t_three_wire();
    t_four_wire_oe();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule